// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits between a serial slave front end and a small byte-wide storage array. After a start condition and a word address, the front end strobes data bytes one at a time. The block collects them in a 16-byte staging buffer and acknowledges each byte it takes. When the front end reports a stop condition, the block commits the staged bytes to the array in one timed internal write cycle.

The word address picks a page and a starting offset within that page. Each byte moves the offset forward by one, and the offset wraps inside the page, so a single transfer never leaves its page. A per-location valid mask records which offsets were received. During the commit only those offsets are written, and the other bytes of the page keep their old contents.

While the commit runs, `busy` is high for a fixed, parameterized number of clocks. The block ignores every request during that time. A new start condition that arrives before the stop throws the staged bytes away. A read port lets the surrounding logic fetch array contents.

Top module: `pgw_top`

## Requirements
- R1: After reset, `busy` and `byte_ack` are both low.
- R2: A data byte that is accepted (`byte_valid` high while an address has been loaded and no commit runs) produces `byte_ack` high for exactly the one cycle after the strobe. A byte that is not accepted produces no `byte_ack`.
- R3: A word address sets the page from `addr_in[6:4]` and the starting offset from `addr_in[3:0]`. Each following byte lands at the next offset, and the offset wraps from 15 back to 0 inside the same page.
- R4: The array does not change before the stop. A stop that follows at least one accepted byte raises `busy` in the cycle after the stop strobe.
- R5: `busy` stays high for exactly `TWR_CYCLES` clocks. After it falls, the array holds every committed byte.
- R6: While `busy` is high, `byte_valid`, `addr_load`, `bus_start` and `bus_stop` have no effect, and no `byte_ack` is produced.
- R7: Only the page offsets that received a byte are written. All other locations keep their previous values.
- R8: If more than 16 bytes are sent, each later byte replaces the earlier byte at the same offset, and the last one is committed.
- R9: A start condition before the stop discards the staged bytes, and nothing is written. A stop with no accepted byte does not raise `busy`.
- R10: `rd_data` shows the array byte at `rd_addr` one clock after the address is applied.
- R11: A data byte that arrives after a stop or start, with no new word address, is ignored and not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse: start condition seen |
| bus_stop | input | 1 | One-cycle pulse: stop condition seen |
| addr_load | input | 1 | One-cycle pulse: word address valid on `addr_in` |
| addr_in | input | 7 | Word address (page and offset) |
| byte_valid | input | 1 | One-cycle pulse: data byte valid on `byte_in` |
| byte_in | input | 8 | Data byte |
| byte_ack | output | 1 | Acknowledge for an accepted byte |
| busy | output | 1 | High during the internal write cycle |
| rd_addr | input | 7 | Array read address |
| rd_data | output | 8 | Array read data, one cycle latency |

## Verification
The commit path is exercised with four kinds of write:
- A full 16-byte write from offset 0 shows that the offsets advance and the page is chosen correctly.
- A short write that starts near the end of a page tells the wrap inside the page apart from a carry into the next page. Reading the whole page afterwards separates masked writes from whole-page writes.
- An 18-byte write tells overwrite-on-wrap apart from dropping the extra bytes.
- Transfers cut short by a repeated start, or by a stop with no data, separate a discarded buffer from a committed one.

Requests sent while `busy` is high show that a running cycle cannot be lengthened, restarted or fed new bytes.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_COMMIT = 2'd2
  } pgw_state_e;

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     load,
  input  logic [PAGE_W-1:0]        load_ptr,
  input  logic                     wr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [PAGE_W-1:0]        rd_idx,
  output logic [(1<<PAGE_W)-1:0]   valid_mask,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_W-1:0]     ptr_q, ptr_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];

  // next state of pointer and mask
  always_comb begin
    mask_d = mask_q;
    ptr_d  = ptr_q;
    if (clr) begin
      mask_d = '0;
    end else if (load) begin
      mask_d = '0;
      ptr_d  = load_ptr;
    end else if (wr) begin
      mask_d[ptr_q] = 1'b1;
      ptr_d         = ptr_q + 1'b1;  // wraps inside the page
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
    end else begin
      mask_q <= mask_d;
      ptr_q  <= ptr_d;
    end
  end

  // data slots carry no reset; the mask qualifies them
  always_ff @(posedge clk) begin
    if (wr && !clr && !load) begin
      slot_q[ptr_q] <= wr_data;
    end
  end

  assign valid_mask = mask_q;
  assign rd_data    = slot_q[rd_idx];

endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int TWR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_load,
  input  logic              byte_valid,
  input  logic              buf_has_data,
  output logic              buf_clr,
  output logic              buf_load,
  output logic              buf_wr,
  output logic              commit_en,
  output logic [PAGE_W-1:0] commit_idx,
  output logic              busy,
  output logic              byte_ack
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CW         = $clog2(TWR_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(TWR_CYCLES - 1);
  localparam logic [CW-1:0] PAGE_CNT = CW'(PAGE_BYTES);

  pgw_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          ack_q;

  // next-state logic; priority: start, stop, address, data
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    buf_clr  = 1'b0;
    buf_load = 1'b0;
    buf_wr   = 1'b0;
    case (state_q)
      ST_IDLE, ST_FILL: begin
        if (bus_start) begin
          buf_clr = 1'b1;
          state_d = ST_IDLE;
        end else if (bus_stop) begin
          if (state_q == ST_FILL && buf_has_data) begin
            state_d = ST_COMMIT;
            cnt_d   = '0;
          end else begin
            buf_clr = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (addr_load) begin
          buf_load = 1'b1;
          state_d  = ST_FILL;
        end else if (byte_valid && state_q == ST_FILL) begin
          buf_wr = 1'b1;
        end
      end
      ST_COMMIT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_CNT) begin
          state_d = ST_IDLE;
          buf_clr = 1'b1;
          cnt_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = (state_q == ST_COMMIT) || (state_d == ST_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      ack_q <= buf_wr;
    end
  end

  // one buffered location per clock during the first cycles of the commit
  assign commit_en  = (state_q == ST_COMMIT) && (cnt_q < PAGE_CNT);
  assign commit_idx = cnt_q[PAGE_W-1:0];
  assign busy       = (state_q == ST_COMMIT);
  assign byte_ack   = ack_q;

endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= mem_q[raddr];
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/pgw_top.sv
module pgw_top #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 4,
  parameter int TWR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  output logic              byte_ack,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;

  logic                  buf_clr, buf_load, buf_wr;
  logic                  commit_en;
  logic [PAGE_W-1:0]     commit_idx;
  logic [PAGE_BYTES-1:0] valid_mask;
  logic [DATA_W-1:0]     stage_byte;
  logic [PG_W-1:0]       page_q;
  logic                  array_we;
  logic [ADDR_W-1:0]     array_waddr;

  pgw_seq #(
    .PAGE_W     (PAGE_W),
    .TWR_CYCLES (TWR_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .addr_load    (addr_load),
    .byte_valid   (byte_valid),
    .buf_has_data (|valid_mask),
    .buf_clr      (buf_clr),
    .buf_load     (buf_load),
    .buf_wr       (buf_wr),
    .commit_en    (commit_en),
    .commit_idx   (commit_idx),
    .busy         (busy),
    .byte_ack     (byte_ack)
  );

  pgw_page_buf #(
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (buf_clr),
    .load       (buf_load),
    .load_ptr   (addr_in[PAGE_W-1:0]),
    .wr         (buf_wr),
    .wr_data    (byte_in),
    .rd_idx     (commit_idx),
    .valid_mask (valid_mask),
    .rd_data    (stage_byte)
  );

  // page number captured with the word address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (buf_load) begin
      page_q <= addr_in[ADDR_W-1:PAGE_W];
    end
  end

  assign array_we    = commit_en && valid_mask[commit_idx];
  assign array_waddr = {page_q, commit_idx};

  pgw_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (array_we),
    .waddr (array_waddr),
    .wdata (stage_byte),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int TWR_CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic bus_start,
  input logic bus_stop,
  input logic byte_valid,
  input logic byte_ack,
  input logic busy,
  input logic arr_we
);

  logic [31:0] blen_q;

  // length of the current busy run, counted in the checker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= '0;
    end else if (busy) begin
      blen_q <= blen_q + 32'd1;
    end else begin
      blen_q <= '0;
    end
  end

  a_r2_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack |-> $past(byte_valid));

  a_r4_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen_q == TWR_CYCLES));

  a_r6_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ack);

  a_r7_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  a_r9_start_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !busy) |=> !busy);

endmodule

bind pgw_top pgw_checker #(
  .TWR_CYCLES (TWR_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_start  (bus_start),
  .bus_stop   (bus_stop),
  .byte_valid (byte_valid),
  .byte_ack   (byte_ack),
  .busy       (busy),
  .arr_we     (array_we)
);

// File: tb/sim_pgw_top.sv
module sim_pgw_top;

  localparam int AW  = 7;
  localparam int DW  = 8;
  localparam int PW  = 4;
  localparam int PB  = 1 << PW;
  localparam int TWR = 40;

  logic          clk;
  logic          rst_n;
  logic          bus_start, bus_stop, addr_load, byte_valid;
  logic [AW-1:0] addr_in, rd_addr;
  logic [DW-1:0] byte_in, rd_data;
  logic          byte_ack, busy;

  pgw_top #(
    .ADDR_W (AW), .DATA_W (DW), .PAGE_W (PW), .TWR_CYCLES (TWR)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .bus_start (bus_start), .bus_stop (bus_stop),
    .addr_load (addr_load), .addr_in (addr_in), .byte_valid (byte_valid),
    .byte_in (byte_in), .byte_ack (byte_ack), .busy (busy),
    .rd_addr (rd_addr), .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [7:0] mdl [128];
  logic [7:0] bdat [PB];
  bit [PB-1:0] bmask;
  int  bpage, bptr, busy_t0;
  bit  armed, mbusy;

  typedef struct {
    int    due;
    int    addr;
    int    exp;
    string tag;
  } rd_item_t;
  rd_item_t rq[$];
  rd_item_t mon_it;

  // scoreboard monitor: compares read data one cycle after each request
  always @(negedge clk) begin
    while (rq.size() > 0 && rq[0].due == cyc) begin
      mon_it = rq.pop_front();
      check(rd_data == mon_it.exp[7:0], mon_it.tag, int'(rd_data), mon_it.exp);
    end
  end

  task automatic do_start();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
    if (!mbusy) begin armed = 0; bmask = '0; end
  endtask

  task automatic do_addr(int a);
    @(negedge clk) begin addr_load = 1'b1; addr_in = AW'(a); end
    @(negedge clk) addr_load = 1'b0;
    if (!mbusy) begin
      armed = 1; bpage = a / PB; bptr = a % PB; bmask = '0;
    end
  endtask

  task automatic do_byte(int d, string tag);
    bit acc;
    @(negedge clk) begin byte_valid = 1'b1; byte_in = d[7:0]; end
    acc = armed && !mbusy;
    if (acc) begin
      bdat[bptr] = d[7:0]; bmask[bptr] = 1'b1; bptr = (bptr + 1) % PB;
    end
    @(negedge clk) byte_valid = 1'b0;
    check(byte_ack == acc, tag, int'(byte_ack), int'(acc));
  endtask

  task automatic do_stop(string tag);
    bit go;
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
    if (!mbusy) begin
      go = armed && (bmask != '0);
      check(busy == go, tag, int'(busy), int'(go));
      if (go) begin
        mbusy = 1; busy_t0 = cyc;
        for (int i = 0; i < PB; i++) if (bmask[i]) mdl[bpage*PB + i] = bdat[i];
      end
      armed = 0; bmask = '0;
    end
  endtask

  task automatic wait_idle(string tag);
    while (busy) @(negedge clk);
    check(cyc - busy_t0 == TWR, tag, cyc - busy_t0, TWR);
    mbusy = 0;
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk) rd_addr = AW'(a);
    rq.push_back('{cyc + 1, a, int'(mdl[a]), tag});
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_start = 0; bus_stop = 0; addr_load = 0; byte_valid = 0;
    addr_in = '0; byte_in = '0; rd_addr = '0;
    armed = 0; mbusy = 0; bmask = '0; bpage = 0; bptr = 0; busy_t0 = 0;
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(byte_ack == 1'b0, "R1 ack", int'(byte_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // full pages 2 and 3 (R2, R3, R5, R10)
    do_start(); do_addr(8'h20);
    for (int i = 0; i < PB; i++) do_byte(8'hA0 ^ i, "R2 ack");
    do_stop("R4 busy rises"); wait_idle("R5 busy length");
    do_start(); do_addr(8'h30);
    for (int i = 0; i < PB; i++) do_byte(8'h5C + i, "R2 ack");
    do_stop("R4 busy rises"); wait_idle("R5 busy length");
    for (int a = 8'h20; a < 8'h40; a++) rd(a, "R10 R3 readback");
    drain();

    // short write with wrap inside page 2 (R3, R4, R7)
    do_start(); do_addr(8'h2D);
    for (int i = 0; i < 5; i++) do_byte(8'h11 + i, "R2 ack");
    rd(8'h2D, "R4 unchanged before stop");
    rd(8'h20, "R4 unchanged before stop");
    drain();
    do_stop("R4 busy rises"); wait_idle("R5 busy length");
    for (int a = 8'h20; a < 8'h30; a++) rd(a, "R7 R3 masked wrap");
    drain();

    // 18 bytes into page 3 (R8)
    do_start(); do_addr(8'h34);
    for (int i = 0; i < PB + 2; i++) do_byte(8'h70 + i, "R8 ack");
    do_stop("R8 busy rises"); wait_idle("R8 busy length");
    for (int a = 8'h30; a < 8'h40; a++) rd(a, "R8 overwrite");
    drain();

    // repeated start discards, empty stop does nothing (R9)
    do_start(); do_addr(8'h22);
    for (int i = 0; i < 3; i++) do_byte(8'hC0 + i, "R2 ack");
    do_start();
    do_stop("R9 no busy after restart");
    do_start(); do_addr(8'h25);
    do_stop("R9 no busy without data");
    for (int a = 8'h20; a < 8'h30; a++) rd(a, "R9 page intact");
    drain();

    // requests during busy are ignored (R6), stray byte afterwards (R11)
    do_start(); do_addr(8'h38);
    do_byte(8'hE1, "R2 ack"); do_byte(8'hE2, "R2 ack");
    do_stop("R4 busy rises");
    do_byte(8'h99, "R6 no ack while busy");
    do_addr(8'h3A);
    do_start();
    do_byte(8'h98, "R6 no ack while busy");
    do_stop("R6 stop ignored");
    wait_idle("R6 busy length unchanged");
    do_byte(8'h77, "R11 byte without address");
    for (int a = 8'h30; a < 8'h40; a++) rd(a, "R6 R7 only two bytes");
    drain();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule